// File: doc/BRIEF.md
# Frequency-Hopping Sine/Cosine Oscillator

A phase accumulator advances by a step on every enabled clock and drives a quarter-wave sine table. It produces a signed sine sample and, when the dual-output parameter is set, a cosine sample taken one quarter turn ahead. The step comes from one of two sources. The first is a direct increment input. The second is one of sixteen hopping registers, picked at run time by a select input.

The hopping registers are loaded through a plain address/data port with a write strobe. A signed frequency-modulation word is added to the chosen step before the accumulator. A phase-modulation word is added at the top of the accumulator output, after the accumulation, so it shifts the phase without changing the frequency. A single clock enable freezes the accumulator, the pipeline and the valid flag. The valid flag rises once two enabled edges have passed since reset.

Top module: `fh_nco`

## Requirements
- R1: While reset is low and right after it, `valid_o`, `sin_o` and `cos_o` are zero, the accumulator is zero and every hopping register is zero.
- R2: When `clken_i` is low, `sin_o`, `cos_o` and `valid_o` keep their values and the accumulator does not advance.
- R3: `valid_o` goes high after the second enabled clock edge following reset and then stays high. The first valid sample corresponds to accumulator value zero.
- R4: With `hop_en_i` low, the accumulator adds `phi_inc_i` on each enabled edge and wraps modulo 2^ACC_W.
- R5: On an edge with `wr_en_i` high, hopping register `wr_addr_i` (4 bits, entries 0 to 15) takes `wr_data_i`. With `wr_en_i` low, no register changes. The new value first steers the accumulator on the following edge.
- R6: With `hop_en_i` high, the step is hopping register `sel_i` (4 bits).
- R7: `fm_i` is sign-extended and added to the selected step on each enabled edge.
- R8: `pm_i` is added to the top PM_W bits of the accumulator value when the phase stage registers it. It never enters the accumulator, so removing it returns the output to the unmodulated track.
- R9: Let ph be the top LUT_AW+2 bits of the modulated phase, registered from the accumulator one enabled edge earlier. Then `sin_o` is round((2^(MAG_W-1)-1)·sin(2π(ph+0.5)/2^(LUT_AW+2))), within 1 LSB. A phase in the first half of the period never yields a negative sample.
- R10: `cos_o` equals the R9 sine at ph + 2^LUT_AW, which is a quarter period ahead.
- R11: Hopping-register writes do not depend on `clken_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clken_i | input | 1 | Clock enable for accumulator, pipeline and valid |
| hop_en_i | input | 1 | 1: step from hopping register, 0: from `phi_inc_i` |
| phi_inc_i | input | ACC_W | Direct phase increment |
| fm_i | input | FM_W | Signed frequency-modulation offset |
| pm_i | input | PM_W | Phase-modulation offset at the top of the phase |
| wr_en_i | input | 1 | Hopping-register write strobe |
| wr_addr_i | input | 4 | Hopping-register write address |
| wr_data_i | input | ACC_W | Hopping-register write data |
| sel_i | input | 4 | Active hopping-register select |
| sin_o | output | MAG_W | Signed sine sample |
| cos_o | output | MAG_W | Signed cosine sample (zero when single output) |
| valid_o | output | 1 | Samples valid |

## Verification
The tests use several step patterns.
- A small direct increment walks through every quadrant, which exposes errors in the table mirroring and the sign.
- A near-full-scale increment forces the accumulator to wrap on almost every edge.
- Distinct hopping values with a changing select show whether the right register drives the step.
- A rewrite of the active entry shows when a new value takes effect.
- A strobe-less write with an otherwise valid address shows whether writes without the strobe are ignored.
- Positive and negative modulation words separate sign extension from zero extension.
- A quarter-turn phase offset, applied and then removed, tells a phase offset apart from one that leaks into the accumulator.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;

  // Quarter-wave magnitude at midpoint (k+0.5) of 2^aw bins, scaled to 2^(mw-1)-1.
  // Fixed-point Taylor series in Q30, evaluated at elaboration.
  function automatic int qsin_entry(input int k, input int aw, input int mw);
    longint half_pi_q30;
    longint x;
    longint x2;
    longint term;
    longint sum;
    longint amp_max;
    half_pi_q30 = 64'sd1686629713;
    x    = (half_pi_q30 * longint'(2 * k + 1)) / (longint'(2) << aw);
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int n = 1; n <= 6; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    amp_max = (longint'(1) << (mw - 1)) - 1;
    return int'((sum * amp_max + (longint'(1) << 29)) >>> 30);
  endfunction

endpackage

// File: rtl/nco_hop_bank.sv
`timescale 1ns/1ps
module nco_hop_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[e] <= '0;
      end else if (wr_en_i && (wr_addr_i == AW'(e))) begin
        mem_q[e] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_sel_i];

  a_r5_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

  a_r5_no_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));

endmodule

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PM_W  = 16,
  parameter int PH_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [PM_W-1:0]  pm_i,
  output logic [PH_W-1:0]  phase_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] pm_ext;
  logic [PH_W-1:0]  phase_d;

  assign pm_ext  = {pm_i, {(ACC_W-PM_W){1'b0}}};
  // modulated phase, truncated to lookup precision
  assign phase_d = PH_W'((acc_q + pm_ext) >> (ACC_W - PH_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      phase_o <= '0;
    end else if (en_i) begin
      acc_q   <= acc_q + step_i;  // wraps modulo 2^ACC_W
      phase_o <= phase_d;
    end
  end

  a_r2_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q) && $stable(phase_o));

  a_r8_pm_outside_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/nco_sine_lut.sv
`timescale 1ns/1ps
module nco_sine_lut #(
  parameter int LUT_AW = 8,
  parameter int MAG_W  = 12,
  localparam int PH_W  = LUT_AW + 2,
  localparam int DEPTH = 1 << LUT_AW,
  localparam int MW1   = MAG_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [PH_W-1:0]         phase_i,
  output logic signed [MAG_W-1:0] amp_o
);

  logic [MW1-1:0]          rom [DEPTH];
  logic [1:0]              quad;
  logic [LUT_AW-1:0]       idx;
  logic [LUT_AW-1:0]       addr;
  logic [MW1-1:0]          mag;
  logic signed [MAG_W-1:0] amp_d;

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = MW1'(nco_pkg::qsin_entry(k, LUT_AW, MAG_W));
  end

  assign quad = phase_i[PH_W-1 -: 2];
  assign idx  = phase_i[LUT_AW-1:0];

  always_comb begin
    case (quad)
      2'd0:    begin addr = idx;  amp_d =  $signed({1'b0, rom[idx]}); end
      2'd1:    begin addr = ~idx; amp_d =  $signed({1'b0, rom[~idx]}); end
      2'd2:    begin addr = idx;  amp_d = -$signed({1'b0, rom[idx]}); end
      default: begin addr = ~idx; amp_d = -$signed({1'b0, rom[~idx]}); end
    endcase
  end

  assign mag = rom[addr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   amp_o <= '0;
    else if (en_i) amp_o <= amp_d;
  end

  a_r9_first_half_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !phase_i[PH_W-1]) |=> !amp_o[MAG_W-1]);

  a_r9_sign_follows_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mag != '0) |=> amp_o[MAG_W-1] == $past(phase_i[PH_W-1]));

endmodule

// File: rtl/fh_nco.sv
`timescale 1ns/1ps
module fh_nco #(
  parameter int ACC_W    = 32,
  parameter int FM_W     = 16,
  parameter int PM_W     = 16,
  parameter int MAG_W    = 12,
  parameter int LUT_AW   = 8,
  parameter int BANK_N   = 16,
  parameter bit DUAL_OUT = 1'b1,
  localparam int SEL_W   = $clog2(BANK_N),
  localparam int PH_W    = LUT_AW + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clken_i,
  input  logic                    hop_en_i,
  input  logic [ACC_W-1:0]        phi_inc_i,
  input  logic [FM_W-1:0]         fm_i,
  input  logic [PM_W-1:0]         pm_i,
  input  logic                    wr_en_i,
  input  logic [SEL_W-1:0]        wr_addr_i,
  input  logic [ACC_W-1:0]        wr_data_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic signed [MAG_W-1:0] sin_o,
  output logic signed [MAG_W-1:0] cos_o,
  output logic                    valid_o
);

  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << LUT_AW;

  logic [ACC_W-1:0] hop_word;
  logic [ACC_W-1:0] base_step;
  logic [ACC_W-1:0] fm_ext;
  logic [ACC_W-1:0] step;
  logic [PH_W-1:0]  phase;
  logic [1:0]       vld_q;

  nco_hop_bank #(.DEPTH(BANK_N), .DATA_W(ACC_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (sel_i),
    .rd_data_o (hop_word)
  );

  assign base_step = hop_en_i ? hop_word : phi_inc_i;
  assign fm_ext    = {{(ACC_W-FM_W){fm_i[FM_W-1]}}, fm_i};
  assign step      = base_step + fm_ext;

  nco_phase_acc #(.ACC_W(ACC_W), .PM_W(PM_W), .PH_W(PH_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clken_i),
    .step_i  (step),
    .pm_i    (pm_i),
    .phase_o (phase)
  );

  nco_sine_lut #(.LUT_AW(LUT_AW), .MAG_W(MAG_W)) i_sin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clken_i),
    .phase_i (phase),
    .amp_o   (sin_o)
  );

  if (DUAL_OUT) begin : g_cos
    nco_sine_lut #(.LUT_AW(LUT_AW), .MAG_W(MAG_W)) i_cos (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (clken_i),
      .phase_i (phase + QUARTER),
      .amp_o   (cos_o)
    );
  end else begin : g_no_cos
    assign cos_o = '0;
  end

  // two enabled edges fill the phase and lookup stages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (clken_i) vld_q <= {vld_q[0], 1'b1};
  end

  assign valid_o = vld_q[1];

  a_r3_valid_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(clken_i));

  a_r3_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clken_i |=> $stable(valid_o) && $stable(sin_o) && $stable(cos_o));

endmodule

// File: tb/test_fh_nco.sv
`timescale 1ns/1ps
module test_fh_nco;

  localparam int    PH_W = 10;
  localparam real   AMAX = 2047.0;
  localparam real   PI   = 3.14159265358979;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               clken_i;
  logic               hop_en_i;
  logic [31:0]        phi_inc_i;
  logic [15:0]        fm_i;
  logic [15:0]        pm_i;
  logic               wr_en_i;
  logic [3:0]         wr_addr_i;
  logic [31:0]        wr_data_i;
  logic [3:0]         sel_i;
  logic signed [11:0] sin_o;
  logic signed [11:0] cos_o;
  logic               valid_o;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";

  // bench model
  logic [31:0]     acc_m;
  logic [PH_W-1:0] ph1, ph2;
  int              vcnt;
  logic [31:0]     bank_m [16];

  always #4 clk_i = ~clk_i;  // 125 MHz

  fh_nco i_fh_nco (
    .clk_i, .rst_ni, .clken_i, .hop_en_i, .phi_inc_i, .fm_i, .pm_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .sel_i, .sin_o, .cos_o, .valid_o
  );

  function automatic int exp_amp(input logic [PH_W-1:0] ph);
    real v;
    v = AMAX * $sin(2.0 * PI * (real'(ph) + 0.5) / real'(1 << PH_W));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic check_amp(input string tag, input int act, input int exp_v);
    int d;
    d = act - exp_v;
    check(tag, d >= -1 && d <= 1, act, exp_v);
  endtask

  task automatic tick();
    logic [31:0] st;
    @(posedge clk_i);
    if (clken_i) begin
      st    = (hop_en_i ? bank_m[sel_i] : phi_inc_i) + {{16{fm_i[15]}}, fm_i};
      ph2   = ph1;
      ph1   = PH_W'((acc_m + {pm_i, 16'h0}) >> (32 - PH_W));
      acc_m = acc_m + st;
      if (vcnt < 2) vcnt++;
    end
    if (wr_en_i) bank_m[wr_addr_i] = wr_data_i;
    @(negedge clk_i);
    check({"R3 valid ", cur_tag}, valid_o == (vcnt >= 2), int'(valid_o), int'(vcnt >= 2));
    if (vcnt >= 2) begin
      check_amp({"R9 sin ", cur_tag}, int'(sin_o), exp_amp(ph2));
      check_amp({"R10 cos ", cur_tag}, int'(cos_o), exp_amp(ph2 + PH_W'(256)));
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic t_reset();
    cur_tag = "R1";
    rst_ni = 1'b0; clken_i = 1'b1; hop_en_i = 1'b0; phi_inc_i = '0;
    fm_i = '0; pm_i = '0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; sel_i = '0;
    acc_m = '0; ph1 = '0; ph2 = '0; vcnt = 0;
    for (int i = 0; i < 16; i++) bank_m[i] = '0;
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", valid_o == 1'b0, int'(valid_o), 0);
    check("R1 sin in reset", sin_o == 0, int'(sin_o), 0);
    check("R1 cos in reset", cos_o == 0, int'(cos_o), 0);
    rst_ni = 1'b1;
    // bank entries are zero: hopping on any entry keeps phase at zero
    hop_en_i = 1'b1; sel_i = 4'd7;
    run(6);
    check_amp("R1 zero bank holds phase", int'(sin_o), exp_amp('0));
  endtask

  task automatic t_direct();
    cur_tag = "R4 direct";
    hop_en_i = 1'b0; phi_inc_i = 32'h0123_4567;
    run(40);
  endtask

  task automatic t_wrap();
    cur_tag = "R4 wrap";
    phi_inc_i = 32'hF3A0_0001;
    run(20);
    check("R4 accumulator wrapped", acc_m < 32'hF3A0_0001, int'(acc_m >> 16), 0);
  endtask

  task automatic t_hold();
    logic signed [11:0] s0, c0;
    logic v0;
    cur_tag = "R2 hold";
    s0 = sin_o; c0 = cos_o; v0 = valid_o;
    clken_i = 1'b0;
    // write during hold: R11
    wr_en_i = 1'b1; wr_addr_i = 4'd15; wr_data_i = 32'h0777_0000;
    tick();
    wr_en_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R2 sin held", sin_o == s0, int'(sin_o), int'(s0));
      check("R2 cos held", cos_o == c0, int'(cos_o), int'(c0));
      check("R2 valid held", valid_o == v0, int'(valid_o), int'(v0));
    end
    clken_i = 1'b1;
    run(3);
  endtask

  task automatic t_bank();
    cur_tag = "R5 R6 bank";
    for (int e = 0; e < 15; e++) begin
      wr_en_i = 1'b1; wr_addr_i = 4'(e); wr_data_i = 32'h0040_0000 * (e + 1) + 32'h1357;
      tick();
    end
    // strobe low: entry 2 must keep its value
    wr_en_i = 1'b0; wr_addr_i = 4'd2; wr_data_i = 32'h7FFF_FFFF;
    tick();
    hop_en_i = 1'b1;
    for (int s = 0; s < 16; s++) begin
      sel_i = 4'(s);
      run(5);
    end
    cur_tag = "R11 hold write";
    sel_i = 4'd15;
    run(8);
    cur_tag = "R5 no strobe";
    sel_i = 4'd2;
    run(8);
    // rewrite active entry: next edge still uses old value
    cur_tag = "R5 live rewrite";
    wr_en_i = 1'b1; wr_addr_i = 4'd2; wr_data_i = 32'h2200_0000;
    tick();
    wr_en_i = 1'b0;
    run(10);
  endtask

  task automatic t_fm();
    cur_tag = "R7 fm neg";
    hop_en_i = 1'b0; phi_inc_i = 32'h0100_0000;
    fm_i = 16'h8123;
    run(20);
    cur_tag = "R7 fm pos";
    fm_i = 16'h7F00;
    run(20);
    fm_i = '0;
  endtask

  task automatic t_pm();
    cur_tag = "R8 pm on";
    phi_inc_i = 32'h0090_0000;
    pm_i = 16'h4000;
    run(20);
    cur_tag = "R8 pm off";
    pm_i = 16'h0000;
    run(20);
    cur_tag = "R8 pm odd";
    pm_i = 16'hA5C3;
    run(12);
    pm_i = '0;
    run(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_wrap();
    t_hold();
    t_bank();
    t_fm();
    t_pm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule